// File: doc/BRIEF.md
# Watchdog and Shared Time-Base Divider

This block turns one tick stream into every slow timing signal a small controller needs. A binary divider chain built from a prescaler stage and a divider stage advances once per tick. Taps on that chain give a periodic time-base interrupt pulse, a display-drive clock and a buzzer clock, and each tap has its own select input. A system-level mux picks the tick source (dedicated RC oscillator, instruction clock or 32.768 kHz oscillator) and delivers it here as a single-cycle enable on the one system clock.

Next to the chain sits a watchdog counter that advances on the same ticks. Software must clear it before it expires. A configuration input selects one of two clear schemes. In the first, a single clear command is enough. In the second, two separate half-commands must both arrive, in either order. Entering HALT and the external reset pin also clear the watchdog. When the watchdog expires during normal execution, it requests a full chip reset. When it expires while the core is halted, it requests only a warm reset of the program counter and stack pointer. Two status flags are kept here: a time-out flag and a power-down flag.

Top module: `wdt_timebase`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is 0.
- R2: `tb_irq` is a one-cycle pulse every 2^(TB_MIN+`tb_sel`) ticks, with `tb_sel` from 0 to 3. The first pulse comes that many ticks after reset.
- R3: `lcd_clk` is a square wave with a period of 2^(2+`lcd_sel`) ticks, with `lcd_sel` from 0 to 6. The code 7 behaves as 6.
- R4: `bz_clk` is a square wave with a period of 2^(2+`bz_sel`) ticks, with `bz_sel` from 0 to 7.
- R5: The chain and the watchdog advance only in cycles where `tick` is 1. A half-rate tick doubles every period in cycles.
- R6: With the watchdog enabled and no clear event, the watchdog expires on the 2^WDT_LOG2-th tick after the count was last reset. In run mode an expiry gives a one-cycle `chip_rst_req` and sets `to_flag`.
- R7: With `dual_clr`=0, a `clr_cmd` pulse resets the count and clears `to_flag` and `pd_flag`. In this mode `clr1_cmd` and `clr2_cmd` have no effect.
- R8: With `dual_clr`=1, the count resets only once both `clr1_cmd` and `clr2_cmd` have been seen, in either order. The record of seen halves is dropped whenever the count resets. `clr_cmd` has no effect in this mode.
- R9: `halt_cmd` and `ext_rst` each reset the count. `halt_cmd` also sets `pd_flag`, clears `to_flag` and enters halt mode.
- R10: An expiry in halt mode gives a one-cycle `warm_rst_req` instead of `chip_rst_req`, sets `to_flag` and leaves halt mode. The next expiry is therefore a run-mode one.
- R11: With `wdt_en`=0 the watchdog never expires, and clear commands leave `to_flag` and `pd_flag` unchanged.
- R12: A `pwr_up` pulse clears both `to_flag` and `pd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| tick | input | 1 | One-cycle enable from the selected time source |
| wdt_en | input | 1 | Watchdog enable option |
| dual_clr | input | 1 | 0: single clear command; 1: two half-commands |
| clr_cmd | input | 1 | Single clear command strobe |
| clr1_cmd | input | 1 | First half clear strobe |
| clr2_cmd | input | 1 | Second half clear strobe |
| halt_cmd | input | 1 | HALT entry strobe |
| pwr_up | input | 1 | Power-up strobe clearing the status flags |
| ext_rst | input | 1 | External reset pin, clears the watchdog count |
| tb_sel | input | TB_SEL_W | Time-base period select |
| lcd_sel | input | LCD_SEL_W | Display clock tap select |
| bz_sel | input | BZ_SEL_W | Buzzer clock tap select |
| chip_rst_req | output | 1 | Full reset request pulse |
| warm_rst_req | output | 1 | Warm reset request pulse |
| to_flag | output | 1 | Watchdog time-out status |
| pd_flag | output | 1 | Power-down status |
| tb_irq | output | 1 | Time-base interrupt pulse |
| lcd_clk | output | 1 | Selected display clock |
| bz_clk | output | 1 | Selected buzzer clock |

## Verification
The taps are measured as intervals between rising edges, taken at the smallest and largest select codes, at the clamped display code, and with a full-rate and a half-rate tick. This separates a wrong tap index from a missing tick gate. The watchdog is timed in cycles from each clearing event. A clear that was wrongly ignored, or a half-command that wrongly cleared, therefore shows up as a shifted expiry. The two dual-mode orders and the leftover record after an expiry are each timed on their own. Expiries in run mode and in halt mode are told apart by which request pulses and by the flag state around them.

// File: rtl/wdtb_pkg.sv
package wdtb_pkg;
  // Clamp a select code to the highest valid choice.
  function automatic int clamp_sel(input int code, input int hi);
    return (code > hi) ? hi : code;
  endfunction
endpackage

// File: rtl/wdtb_div_chain.sv
module wdtb_div_chain #(
  parameter int PRE_W = 7,
  parameter int DIV_W = 8,
  localparam int CH_W = PRE_W + DIV_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [CH_W-1:0] chain_o
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             pre_wrap;

  assign pre_wrap = tick & (&pre_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      if (tick)     pre_q <= pre_q + 1'b1;
      if (pre_wrap) div_q <= div_q + 1'b1;
    end
  end

  assign chain_o = {div_q, pre_q};
endmodule

// File: rtl/wdtb_tap_sel.sv
module wdtb_tap_sel #(
  parameter int NUM   = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [NUM-1:0]   taps_i,
  output logic             tap_o
);
  logic [SEL_W-1:0] idx;
  logic             tap_q;

  assign idx = SEL_W'(wdtb_pkg::clamp_sel(int'(sel), NUM - 1));

  always_ff @(posedge clk) begin
    if (rst) tap_q <= 1'b0;
    else     tap_q <= taps_i[idx];
  end

  assign tap_o = tap_q;
endmodule

// File: rtl/wdtb_tbase_irq.sv
module wdtb_tbase_irq #(
  parameter int TB_MIN = 12,
  parameter int TB_NUM = 4,
  parameter int SEL_W  = 2,
  localparam int USE_W = TB_MIN + TB_NUM - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [USE_W-1:0] low_i,
  output logic             irq_o
);
  logic [TB_NUM-1:0] wrap;
  logic [SEL_W-1:0]  idx;
  logic              irq_q;

  generate
    for (genvar i = 0; i < TB_NUM; i++) begin : g_wrap
      assign wrap[i] = &low_i[TB_MIN+i-1:0];
    end
  endgenerate

  assign idx = SEL_W'(wdtb_pkg::clamp_sel(int'(sel), TB_NUM - 1));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= tick & wrap[idx];
  end

  assign irq_o = irq_q;

  p_tb_single_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/wdtb_watchdog.sv
module wdtb_watchdog #(
  parameter int WDT_LOG2 = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wdt_en,
  input  logic dual_clr,
  input  logic clr_cmd,
  input  logic clr1_cmd,
  input  logic clr2_cmd,
  input  logic halt_cmd,
  input  logic pwr_up,
  input  logic ext_rst,
  output logic chip_rst_o,
  output logic warm_rst_o,
  output logic to_o,
  output logic pd_o
);
  logic [WDT_LOG2-1:0] cnt_q;
  logic seen1_q, seen2_q, halt_q;
  logic chip_q, warm_q, to_q, pd_q;
  logic accept, hold_clr, expire;

  always_comb begin
    accept   = wdt_en & ((~dual_clr & clr_cmd) |
               (dual_clr & (seen1_q | clr1_cmd) & (seen2_q | clr2_cmd)));
    hold_clr = accept | halt_cmd | ext_rst;
    expire   = wdt_en & tick & (&cnt_q) & ~hold_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
      halt_q  <= 1'b0;
      chip_q  <= 1'b0;
      warm_q  <= 1'b0;
      to_q    <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      if (!wdt_en || hold_clr || expire) cnt_q <= '0;
      else if (tick)                     cnt_q <= cnt_q + 1'b1;

      if (!wdt_en || !dual_clr || hold_clr || expire) begin
        seen1_q <= 1'b0;
        seen2_q <= 1'b0;
      end else begin
        seen1_q <= seen1_q | clr1_cmd;
        seen2_q <= seen2_q | clr2_cmd;
      end

      chip_q <= expire & ~halt_q;
      warm_q <= expire & halt_q;

      if (halt_cmd)                          halt_q <= 1'b1;
      else if (pwr_up || accept || expire)   halt_q <= 1'b0;

      if (pwr_up)        pd_q <= 1'b0;
      else if (halt_cmd) pd_q <= 1'b1;
      else if (accept)   pd_q <= 1'b0;

      if (pwr_up || accept || halt_cmd) to_q <= 1'b0;
      else if (expire)                  to_q <= 1'b1;
    end
  end

  assign chip_rst_o = chip_q;
  assign warm_rst_o = warm_q;
  assign to_o       = to_q;
  assign pd_o       = pd_q;

  p_req_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(chip_q && warm_q));
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    chip_q |=> !chip_q);
  p_halt_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (halt_cmd && !pwr_up) |=> (pd_q && !to_q));
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!wdt_en && $past(!wdt_en)) |-> !(chip_q || warm_q));
  p_pwrup_r12: assert property (@(posedge clk) disable iff (rst)
    pwr_up |=> (!to_q && !pd_q));
  p_extclr_r9: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> !(chip_q || warm_q));
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int PRE_W     = 7,
  parameter int DIV_W     = 8,
  parameter int WDT_LOG2  = 16,
  parameter int TB_MIN    = 12,
  parameter int TB_NUM    = 4,
  parameter int TB_SEL_W  = 2,
  parameter int LCD_MIN   = 2,
  parameter int LCD_NUM   = 7,
  parameter int LCD_SEL_W = 3,
  parameter int BZ_MIN    = 2,
  parameter int BZ_NUM    = 8,
  parameter int BZ_SEL_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 wdt_en,
  input  logic                 dual_clr,
  input  logic                 clr_cmd,
  input  logic                 clr1_cmd,
  input  logic                 clr2_cmd,
  input  logic                 halt_cmd,
  input  logic                 pwr_up,
  input  logic                 ext_rst,
  input  logic [TB_SEL_W-1:0]  tb_sel,
  input  logic [LCD_SEL_W-1:0] lcd_sel,
  input  logic [BZ_SEL_W-1:0]  bz_sel,
  output logic                 chip_rst_req,
  output logic                 warm_rst_req,
  output logic                 to_flag,
  output logic                 pd_flag,
  output logic                 tb_irq,
  output logic                 lcd_clk,
  output logic                 bz_clk
);
  localparam int CH_W   = PRE_W + DIV_W;
  localparam int TB_USE = TB_MIN + TB_NUM - 1;

  logic [CH_W-1:0] chain;

  wdtb_div_chain #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chain (
    .clk(clk), .rst(rst), .tick(tick), .chain_o(chain));

  wdtb_tbase_irq #(.TB_MIN(TB_MIN), .TB_NUM(TB_NUM), .SEL_W(TB_SEL_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .sel(tb_sel),
    .low_i(chain[TB_USE-1:0]), .irq_o(tb_irq));

  wdtb_tap_sel #(.NUM(LCD_NUM), .SEL_W(LCD_SEL_W)) u_lcd (
    .clk(clk), .rst(rst), .sel(lcd_sel),
    .taps_i(chain[LCD_MIN-1 +: LCD_NUM]), .tap_o(lcd_clk));

  wdtb_tap_sel #(.NUM(BZ_NUM), .SEL_W(BZ_SEL_W)) u_bz (
    .clk(clk), .rst(rst), .sel(bz_sel),
    .taps_i(chain[BZ_MIN-1 +: BZ_NUM]), .tap_o(bz_clk));

  wdtb_watchdog #(.WDT_LOG2(WDT_LOG2)) u_wdt (
    .clk(clk), .rst(rst), .tick(tick), .wdt_en(wdt_en), .dual_clr(dual_clr),
    .clr_cmd(clr_cmd), .clr1_cmd(clr1_cmd), .clr2_cmd(clr2_cmd),
    .halt_cmd(halt_cmd), .pwr_up(pwr_up), .ext_rst(ext_rst),
    .chip_rst_o(chip_rst_req), .warm_rst_o(warm_rst_req),
    .to_o(to_flag), .pd_o(pd_flag));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(chip_rst_req || warm_rst_req || tb_irq));
endmodule

// File: tb/wdt_timebase_tb_top.sv
module wdt_timebase_tb_top;
  localparam int TB_MIN = 6;
  localparam int WLEN   = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic wdt_en = 1'b0, dual_clr = 1'b0;
  logic clr_cmd = 1'b0, clr1_cmd = 1'b0, clr2_cmd = 1'b0;
  logic halt_cmd = 1'b0, pwr_up = 1'b0, ext_rst = 1'b0;
  logic [1:0] tb_sel = 2'd0;
  logic [2:0] lcd_sel = 3'd0, bz_sel = 3'd0;
  logic chip_rst_req, warm_rst_req, to_flag, pd_flag, tb_irq, lcd_clk, bz_clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wdt_timebase #(.PRE_W(4), .DIV_W(5), .WDT_LOG2(8), .TB_MIN(TB_MIN)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wdt_en(wdt_en), .dual_clr(dual_clr),
    .clr_cmd(clr_cmd), .clr1_cmd(clr1_cmd), .clr2_cmd(clr2_cmd),
    .halt_cmd(halt_cmd), .pwr_up(pwr_up), .ext_rst(ext_rst),
    .tb_sel(tb_sel), .lcd_sel(lcd_sel), .bz_sel(bz_sel),
    .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req),
    .to_flag(to_flag), .pd_flag(pd_flag), .tb_irq(tb_irq),
    .lcd_clk(lcd_clk), .bz_clk(bz_clk));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return tb_irq;
      1: return lcd_clk;
      default: return bz_clk;
    endcase
  endfunction

  // Interval in cycles between the 2nd and 3rd rising edge of the chosen output.
  task automatic measure(input int which, input bit half, output int per);
    int rises = 0;
    int last = 0;
    int n = 0;
    logic prev;
    per = -1;
    step(); step();
    prev = pick(which);
    for (int k = 0; k < 4000 && rises < 3; k++) begin
      if (half) tick = ~tick;
      step();
      n++;
      if (pick(which) && !prev) begin
        rises++;
        if (rises == 3) per = n - last;
        last = n;
      end
      prev = pick(which);
    end
    tick = 1'b1;
  endtask

  task automatic wait_req(output int n, output int chip, output int warm);
    n = -1; chip = 0; warm = 0;
    for (int k = 1; k <= 3000; k++) begin
      step();
      if (chip_rst_req || warm_rst_req) begin
        n = k; chip = chip_rst_req; warm = warm_rst_req;
        break;
      end
    end
  endtask

  task automatic pulse_clr();  clr_cmd = 1;  step(); clr_cmd = 0;  endtask
  task automatic pulse_clr1(); clr1_cmd = 1; step(); clr1_cmd = 0; endtask
  task automatic pulse_clr2(); clr2_cmd = 1; step(); clr2_cmd = 0; endtask
  task automatic pulse_halt(); halt_cmd = 1; step(); halt_cmd = 0; endtask
  task automatic pulse_pwr();  pwr_up = 1;   step(); pwr_up = 0;   endtask
  task automatic pulse_ext();  ext_rst = 1;  step(); ext_rst = 0;  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 chip_rst_req in reset", int'(chip_rst_req), 0);
    chk("R1 warm_rst_req in reset", int'(warm_rst_req), 0);
    chk("R1 to_flag in reset", int'(to_flag), 0);
    chk("R1 pd_flag in reset", int'(pd_flag), 0);
    rst = 0;
    step();
    chk("R1 tb_irq after reset", int'(tb_irq), 0);
    chk("R1 lcd_clk after reset", int'(lcd_clk), 0);
    chk("R1 bz_clk after reset", int'(bz_clk), 0);
  endtask

  task automatic t_timebase();
    int p;
    tb_sel = 2'd0; measure(0, 1'b0, p); chk("R2 tb period sel0", p, 1 << TB_MIN);
    tb_sel = 2'd3; measure(0, 1'b0, p); chk("R2 tb period sel3", p, 1 << (TB_MIN + 3));
    tb_sel = 2'd1; measure(0, 1'b1, p); chk("R5 tb period sel1 half-rate", p, 2 << (TB_MIN + 1));
  endtask

  task automatic t_taps();
    int p;
    lcd_sel = 3'd0; measure(1, 1'b0, p); chk("R3 lcd period sel0", p, 4);
    lcd_sel = 3'd6; measure(1, 1'b0, p); chk("R3 lcd period sel6", p, 256);
    lcd_sel = 3'd7; measure(1, 1'b0, p); chk("R3 lcd period sel7 clamps", p, 256);
    lcd_sel = 3'd2; measure(1, 1'b1, p); chk("R5 lcd period sel2 half-rate", p, 32);
    bz_sel = 3'd0;  measure(2, 1'b0, p); chk("R4 bz period sel0", p, 4);
    bz_sel = 3'd7;  measure(2, 1'b0, p); chk("R4 bz period sel7", p, 512);
  endtask

  task automatic t_disabled();
    int seen = 0;
    wdt_en = 0;
    for (int k = 0; k < 600; k++) begin
      step();
      if (chip_rst_req || warm_rst_req) seen++;
    end
    chk("R11 no expiry while disabled", seen, 0);
    pulse_halt();
    chk("R9 halt sets pd", int'(pd_flag), 1);
    pulse_clr();
    chk("R11 clear ignored when disabled, pd", int'(pd_flag), 1);
    pulse_pwr();
    chk("R12 pwr_up clears pd", int'(pd_flag), 0);
  endtask

  task automatic t_run_timeout();
    int n, c, w;
    wdt_en = 1; dual_clr = 0;
    pulse_clr();
    wait_req(n, c, w);
    chk("R6 run expiry cycles", n, WLEN);
    chk("R6 chip_rst_req", c, 1);
    chk("R6 no warm request", w, 0);
    chk("R6 to_flag set", int'(to_flag), 1);
    step();
    chk("R6 request one cycle", int'(chip_rst_req), 0);
  endtask

  task automatic t_single_clear();
    int n, c, w;
    pulse_clr();
    chk("R7 clr clears to_flag", int'(to_flag), 0);
    repeat (199) step();
    pulse_clr();
    repeat (49) step();
    pulse_clr1();
    pulse_clr2();
    wait_req(n, c, w);
    chk("R7 clr restarts count, halves ignored", n, WLEN - 51);
  endtask

  task automatic t_dual();
    int n, c, w;
    dual_clr = 1;
    step();
    pulse_ext();
    repeat (99) step();
    pulse_clr1();
    repeat (19) step();
    pulse_clr();
    wait_req(n, c, w);
    chk("R8 R9 ext_rst clears, one half and clr_cmd do not", n, WLEN - 120);
    chk("R8 to_flag after expiry", int'(to_flag), 1);
    pulse_clr2();
    repeat (29) step();
    pulse_clr1();
    chk("R8 pair clears to_flag", int'(to_flag), 0);
    wait_req(n, c, w);
    chk("R8 order clr2 then clr1, record dropped at expiry", n, WLEN);
    pulse_clr1();
    repeat (9) step();
    pulse_clr2();
    wait_req(n, c, w);
    chk("R8 order clr1 then clr2", n, WLEN);
    dual_clr = 0;
    step();
  endtask

  task automatic t_halt();
    int n, c, w;
    pulse_halt();
    chk("R9 halt sets pd", int'(pd_flag), 1);
    chk("R9 halt clears to", int'(to_flag), 0);
    wait_req(n, c, w);
    chk("R9 halt restarts count", n, WLEN);
    chk("R10 warm request when halted", w, 1);
    chk("R10 no chip request when halted", c, 0);
    chk("R10 to_flag set", int'(to_flag), 1);
    wait_req(n, c, w);
    chk("R10 next expiry is run mode", c, 1);
    pulse_clr();
    chk("R7 clr clears pd", int'(pd_flag), 0);
    chk("R7 clr clears to", int'(to_flag), 0);
  endtask

  task automatic t_pwrup();
    int n, c, w;
    wait_req(n, c, w);
    chk("R6 to set before pwr_up", int'(to_flag), 1);
    pulse_halt();
    pulse_pwr();
    chk("R12 pwr_up clears to", int'(to_flag), 0);
    chk("R12 pwr_up clears pd", int'(pd_flag), 0);
  endtask

  initial begin
    t_reset();
    t_timebase();
    t_taps();
    t_disabled();
    t_run_timeout();
    t_single_clear();
    t_dual();
    t_halt();
    t_pwrup();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule